// File: doc/BRIEF.md
# Two-Address Instruction Sequencer

This block is a compact execution core that runs one instruction per clock from an external instruction memory. Every instruction word is 16 bits wide: a 4-bit operation code in the top nibble, a first operand field in bits [11:6] and a second operand field in bits [5:0]. The core keeps a 12-bit program counter, a 64-entry by 16-bit register file and a small hardware stack that holds return addresses. It executes register addition and copy, absolute jumps, a jump taken when a register is zero, and procedure call and return.

The program counter drives the instruction-memory address directly. The memory is read combinationally, so the word at the current address is decoded and retired in the same cycle. A debug select input reads any register combinationally, so a host can inspect results once the core has stopped. The core stops on a HALT instruction. It also stops, and raises a sticky fault, when a call finds the return stack full or a return finds it empty. After reset each register holds its own index, so programs have distinct operand values to work on without a load instruction.

Top module: `seq2a_core`

## Requirements
- R1: Instruction fields: bits [15:12] hold the operation code, bits [11:6] operand A and bits [5:0] operand B; a jump target is the 12-bit value {A,B}, with A as the upper half.
- R2: While reset is held, and on the first cycle after it: the address output is 0, halted and fault are 0, and register k reads back the value k.
- R3: Opcode 1001 (ADD A,B) writes (R[A]+R[B]) mod 2^16 into R[A], including when A equals B, and advances the address by one.
- R4: Opcode 0001 (MOVE A,B) writes R[B] into R[A], leaves R[B] unchanged and advances the address by one.
- R5: Opcode 0010 (JMP) loads the address with {A,B}.
- R6: Opcode 0011 (JZ A,B) loads the address with B zero-extended when R[A] is zero, and otherwise advances it by one.
- R7: Opcode 0100 (CALL) pushes the current address plus one onto the return stack and loads the address with {A,B}.
- R8: Opcode 0101 (RET) pops the most recent stack entry into the address, so nested calls return last-in, first-out.
- R9: The return stack holds 8 entries. A CALL with 8 entries held, or a RET with none, raises fault and halted, leaves the address and the registers unchanged, and fault stays set until reset.
- R10: Opcode 1111 (HALT) raises halted and keeps the address on the HALT word. No further instruction executes until reset.
- R11: Opcode 0000 and every opcode not named above write no register and advance the address by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 12 | Program counter, used as the instruction-memory address |
| imem_data | input | 16 | Instruction word at imem_addr, available in the same cycle |
| dbg_sel | input | 6 | Register index for the debug read |
| dbg_value | output | 16 | Contents of the selected register |
| halted | output | 1 | High once the core has stopped |
| fault | output | 1 | Sticky flag for a return-stack overflow or underflow |

## Verification
The embedded assertions check the following on every cycle:
- halted and fault, once set, stay set, and the address stays frozen while halted.
- fault is never set without halted.
- A jump lands on its encoded target, and a return lands on the stack's top entry.
- Plain instructions advance the address by exactly one.
- The stack is never pushed when full or popped when empty.
- Its occupancy moves by one per operation, and a write to the register file lands at the addressed entry.

Some behaviour can only be shown by running programs and comparing against the bench's arithmetic model:
- The register values after long mixed runs of ADD, MOVE and unused opcodes, including 16-bit wrap-around.
- The unwinding order of an eight-deep call chain.
- The exact instruction at which an overflow or an underflow stops the core.

// File: rtl/seq2a_pkg.sv
package seq2a_pkg;

   // operation codes; the values are the encoding in bits [15:12]
   typedef enum logic [3:0] {
      OP_NOP  = 4'b0000,
      OP_MOVE = 4'b0001,
      OP_JMP  = 4'b0010,
      OP_JZ   = 4'b0011,
      OP_CALL = 4'b0100,
      OP_RET  = 4'b0101,
      OP_ADD  = 4'b1001,
      OP_HALT = 4'b1111
   } opcode_e;

   localparam int OPC_W = 4;

   // one-hot micro-operation produced by the decoder
   typedef struct packed {
      logic wr_sum;
      logic wr_copy;
      logic go;
      logic go_zero;
      logic enter;
      logic leave;
      logic stop;
      logic plain;
   } uop_s;

endpackage

// File: rtl/seq2a_decode.sv
module seq2a_decode
   import seq2a_pkg::*;
#(
   parameter int OPD_W = 6
) (
   input  logic [OPC_W+2*OPD_W-1:0] insn,
   output uop_s                     uop,
   output logic [OPD_W-1:0]         fld_a,
   output logic [OPD_W-1:0]         fld_b
);

   localparam int INSN_W = OPC_W + 2*OPD_W;

   generate
      if (OPD_W < 1) begin : g_bad_opd
         $error("seq2a_decode: OPD_W must be at least 1");
      end
   endgenerate

   opcode_e opc;

   assign opc   = opcode_e'(insn[INSN_W-1 -: OPC_W]);
   assign fld_a = insn[2*OPD_W-1 -: OPD_W];
   assign fld_b = insn[OPD_W-1:0];

   always_comb begin
      uop = '0;
      case (opc)
         OP_ADD  : uop.wr_sum  = 1'b1;
         OP_MOVE : uop.wr_copy = 1'b1;
         OP_JMP  : uop.go      = 1'b1;
         OP_JZ   : uop.go_zero = 1'b1;
         OP_CALL : uop.enter   = 1'b1;
         OP_RET  : uop.leave   = 1'b1;
         OP_HALT : uop.stop    = 1'b1;
         default : uop.plain   = 1'b1;   // R11: NOP and unused codes
      endcase
   end

   // R1: every known word selects exactly one micro-operation
   always_comb begin
      if (!$isunknown(insn)) begin
         p_uop_onehot_r1 : assert ($countones(uop) == 1)
            else $error("decoder produced %0d micro-ops", $countones(uop));
      end
   end

endmodule

// File: rtl/seq2a_regfile.sv
module seq2a_regfile #(
   parameter int AW         = 6,
   parameter int DW         = 16,
   parameter int INIT_INDEX = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ra_sel,
   output logic [DW-1:0] ra_val,
   input  logic [AW-1:0] rb_sel,
   output logic [DW-1:0] rb_val,
   input  logic [AW-1:0] dbg_sel,
   output logic [DW-1:0] dbg_val
);

   localparam int NREG = 1 << AW;

   generate
      if (AW < 1 || AW > 10) begin : g_bad_aw
         $error("seq2a_regfile: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("seq2a_regfile: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] cells [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_cell
      logic [DW-1:0] cell_q;
      logic          hit;

      assign hit = we && (waddr == AW'(i));

      if (INIT_INDEX != 0) begin : g_idx_init
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cell_q <= DW'(i);
            else if (hit) cell_q <= wdata;
         end
      end else begin : g_zero_init
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cell_q <= '0;
            else if (hit) cell_q <= wdata;
         end
      end

      assign cells[i] = cell_q;
   end

   assign ra_val  = cells[ra_sel];
   assign rb_val  = cells[rb_sel];
   assign dbg_val = cells[dbg_sel];

   // R3 / R4: a write is visible at its entry on the next cycle
   p_write_lands_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> cells[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/seq2a_retstack.sv
module seq2a_retstack #(
   parameter int DEPTH = 8,
   parameter int DW    = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] top,
   output logic          full,
   output logic          empty
);

   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("seq2a_retstack: DEPTH must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [DW-1:0] slots [DEPTH];

   assign full  = (cnt_q == CW'(DEPTH));
   assign empty = (cnt_q == '0);
   assign top   = empty ? '0 : slots[IW'(cnt_q - 1'b1)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (push && !full)     cnt_q <= cnt_q + 1'b1;
      else if (pop && !empty)     cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push && !full) slots[IW'(cnt_q)] <= din;
   end

   // R9: the controller never pushes a full stack or pops an empty one
   p_no_push_full_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_no_pop_empty_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   p_depth_bound_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   p_not_both_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

   // R7 / R8: occupancy steps by one and the pushed word becomes the top
   p_push_top_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (top == $past(din)) && (cnt_q == $past(cnt_q) + 1'b1));
   p_pop_step_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/seq2a_core.sv
module seq2a_core
   import seq2a_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int OPD_W         = 6,
   parameter int PC_W          = 12,
   parameter int RS_DEPTH      = 8,
   parameter int RF_INIT_INDEX = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   output logic [PC_W-1:0]            imem_addr,
   input  logic [OPC_W+2*OPD_W-1:0]   imem_data,
   input  logic [OPD_W-1:0]           dbg_sel,
   output logic [DATA_W-1:0]          dbg_value,
   output logic                       halted,
   output logic                       fault
);

   localparam int INSN_W = OPC_W + 2*OPD_W;
   localparam int JT_W   = 2*OPD_W;

   generate
      if (PC_W < JT_W) begin : g_bad_pc
         $error("seq2a_core: PC_W must hold a full jump target");
      end
      if (RS_DEPTH < 1) begin : g_bad_rs
         $error("seq2a_core: RS_DEPTH must be at least 1");
      end
   endgenerate

   // ------------------------------------------------------------ state
   logic [PC_W-1:0]   pc_q, pc_nxt;
   logic              halt_q, fault_q;

   // ------------------------------------------------------------ decode
   uop_s              uop;
   logic [OPD_W-1:0]  fld_a, fld_b;

   seq2a_decode #(.OPD_W(OPD_W)) u_dec (
      .insn  (imem_data),
      .uop   (uop),
      .fld_a (fld_a),
      .fld_b (fld_b)
   );

   // ------------------------------------------------------------ registers
   logic              rf_we;
   logic [DATA_W-1:0] rf_wdata, ra_val, rb_val;

   seq2a_regfile #(
      .AW         (OPD_W),
      .DW         (DATA_W),
      .INIT_INDEX (RF_INIT_INDEX)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (fld_a),
      .wdata   (rf_wdata),
      .ra_sel  (fld_a),
      .ra_val  (ra_val),
      .rb_sel  (fld_b),
      .rb_val  (rb_val),
      .dbg_sel (dbg_sel),
      .dbg_val (dbg_value)
   );

   // ------------------------------------------------------------ return stack
   logic              rs_push, rs_pop, rs_full, rs_empty;
   logic [PC_W-1:0]   rs_top, pc_inc;

   seq2a_retstack #(.DEPTH(RS_DEPTH), .DW(PC_W)) u_rs (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rs_push),
      .pop   (rs_pop),
      .din   (pc_inc),
      .top   (rs_top),
      .full  (rs_full),
      .empty (rs_empty)
   );

   // ------------------------------------------------------------ control
   logic              run, halt_set, fault_set;
   logic [PC_W-1:0]   jump_tgt, zero_tgt;

   assign run      = !halt_q;
   assign pc_inc   = pc_q + 1'b1;
   assign jump_tgt = PC_W'({fld_a, fld_b});
   assign zero_tgt = PC_W'(fld_b);

   always_comb begin
      pc_nxt    = pc_q;
      rf_we     = 1'b0;
      rf_wdata  = ra_val + rb_val;
      rs_push   = 1'b0;
      rs_pop    = 1'b0;
      halt_set  = 1'b0;
      fault_set = 1'b0;
      if (run) begin
         pc_nxt = pc_inc;
         if (uop.wr_sum) rf_we = 1'b1;
         if (uop.wr_copy) begin
            rf_we    = 1'b1;
            rf_wdata = rb_val;
         end
         if (uop.go) pc_nxt = jump_tgt;
         if (uop.go_zero && (ra_val == '0)) pc_nxt = zero_tgt;
         if (uop.enter) begin
            if (rs_full) begin
               fault_set = 1'b1;
               pc_nxt    = pc_q;
            end else begin
               rs_push = 1'b1;
               pc_nxt  = jump_tgt;
            end
         end
         if (uop.leave) begin
            if (rs_empty) begin
               fault_set = 1'b1;
               pc_nxt    = pc_q;
            end else begin
               rs_pop = 1'b1;
               pc_nxt = rs_top;
            end
         end
         if (uop.stop) begin
            halt_set = 1'b1;
            pc_nxt   = pc_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         halt_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         pc_q <= pc_nxt;
         if (halt_set || fault_set) halt_q  <= 1'b1;
         if (fault_set)             fault_q <= 1'b1;
      end
   end

   assign imem_addr = pc_q;
   assign halted    = halt_q;
   assign fault     = fault_q;

   // ------------------------------------------------------------ assertions
   p_halt_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   p_halt_frozen_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(imem_addr));
   p_fault_sticky_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);
   p_fault_halts_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> halted);
   p_call_full_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (run && uop.enter && rs_full) |=> fault && $stable(imem_addr));
   p_jmp_target_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (run && uop.go) |=> imem_addr == $past(jump_tgt));
   p_ret_target_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (run && uop.leave && !rs_empty) |=> imem_addr == $past(rs_top));
   p_seq_advance_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (run && (uop.plain || uop.wr_sum || uop.wr_copy))
         |=> imem_addr == $past(imem_addr) + 1'b1);

endmodule

// File: tb/sim_seq2a_core.sv
module sim_seq2a_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] imem_addr;
   logic [15:0] imem_data;
   logic [5:0]  dbg_sel = '0;
   logic [15:0] dbg_value;
   logic        halted, fault;

   logic [15:0] mem [0:255];

   always #10 clk = ~clk;   // 50 MHz

   assign imem_data = mem[imem_addr[7:0]];

   seq2a_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .imem_addr (imem_addr),
      .imem_data (imem_data),
      .dbg_sel   (dbg_sel),
      .dbg_value (dbg_value),
      .halted    (halted),
      .fault     (fault)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;

   // architectural model built from the requirements
   logic [15:0] m_r   [0:63];
   logic [11:0] m_stk [0:7];
   int          m_sp;
   logic [11:0] m_pc;
   logic        m_halt, m_err;
   string       last_tag;

   // R1: word = {opcode[3:0], A[5:0], B[5:0]}
   function automatic logic [15:0] enc(logic [3:0] op, logic [5:0] a, logic [5:0] b);
      return {op, a, b};
   endfunction

   function automatic logic [15:0] enc_t(logic [3:0] op, logic [11:0] t);
      return {op, t};
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 64; k++) m_r[k] = 16'(k);
      m_sp = 0; m_pc = '0; m_halt = 1'b0; m_err = 1'b0;
      last_tag = "R2";
   endtask

   task automatic model_step();
      logic [15:0] w;
      logic [3:0]  op;
      logic [5:0]  a, b;
      if (m_halt) begin
         last_tag = "R10";
         return;
      end
      w = mem[m_pc[7:0]];
      op = w[15:12]; a = w[11:6]; b = w[5:0];
      case (op)
         4'b1001: begin m_r[a] = m_r[a] + m_r[b]; m_pc = m_pc + 1; last_tag = "R3"; end
         4'b0001: begin m_r[a] = m_r[b]; m_pc = m_pc + 1; last_tag = "R4"; end
         4'b0010: begin m_pc = {a, b}; last_tag = "R5"; end
         4'b0011: begin
            m_pc = (m_r[a] == 16'd0) ? {6'd0, b} : m_pc + 1;
            last_tag = "R6";
         end
         4'b0100: begin
            if (m_sp == 8) begin m_err = 1'b1; m_halt = 1'b1; last_tag = "R9"; end
            else begin m_stk[m_sp] = m_pc + 1; m_sp++; m_pc = {a, b}; last_tag = "R7"; end
         end
         4'b0101: begin
            if (m_sp == 0) begin m_err = 1'b1; m_halt = 1'b1; last_tag = "R9"; end
            else begin m_sp--; m_pc = m_stk[m_sp]; last_tag = "R8"; end
         end
         4'b1111: begin m_halt = 1'b1; last_tag = "R10"; end
         default: begin m_pc = m_pc + 1; last_tag = "R11"; end
      endcase
   endtask

   task automatic dump_regs(string tag);
      for (int k = 0; k < 64; k++) begin
         dbg_sel = 6'(k);
         #1;
         chk(tag, $sformatf("register %0d", k), 32'(dbg_value), 32'(m_r[k]));
      end
   endtask

   task automatic clear_mem();
      for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
   endtask

   task automatic run_prog(string tag);
      int post;
      int steps;
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R2: reset state at the ports
      chk("R2", "reset addr/halted/fault", 32'({imem_addr, halted, fault}), 32'(0));
      dump_regs("R2");
      @(negedge clk);
      rst_n = 1'b1;
      post = 0;
      steps = 0;
      while (post < 3 && steps < 3000) begin
         chk(last_tag, "addr/halted/fault", 32'({imem_addr, halted, fault}),
             32'({m_pc, m_halt, m_err}));
         if (m_halt) post++;
         model_step();
         steps++;
         @(negedge clk);
      end
      if (steps >= 3000) chk(tag, "program end", 32'(steps), 32'(0));
      dump_regs(tag);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL R10 watchdog: got %0d cycles expected fewer than 100000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] undef_ops [0:7];
      int n;
      undef_ops[0] = 4'd6;  undef_ops[1] = 4'd7;  undef_ops[2] = 4'd8;
      undef_ops[3] = 4'd10; undef_ops[4] = 4'd11; undef_ops[5] = 4'd12;
      undef_ops[6] = 4'd13; undef_ops[7] = 4'd14;

      // ---- R1 R3 R4 R11: data sweep with wrap-around and unused codes
      clear_mem();
      n = 0;
      for (int i = 0; i < 12; i++) begin mem[n] = enc(4'b1001, 6'd63, 6'd63); n++; end
      mem[n] = enc(4'b1001, 6'd5, 6'd5); n++;
      mem[n] = enc(4'b0001, 6'd9, 6'd9); n++;
      for (int i = 0; i < 120; i++) begin
         logic [5:0] a, b;
         a = 6'((i * 7 + 3) % 64);
         b = 6'((i * 13 + 5) % 64);
         case (i % 5)
            0: mem[n] = enc(4'b0001, a, b);
            1, 2: mem[n] = enc(4'b1001, a, b);
            3: mem[n] = enc(4'b0000, a, b);
            default: mem[n] = enc(undef_ops[i % 8], a, b);
         endcase
         n++;
      end
      mem[n] = enc(4'b1111, 6'd0, 6'd0);
      run_prog("R1");

      // ---- R5 R6 R7 R8 R10: control flow
      clear_mem();
      mem[0]   = enc_t(4'b0100, 12'd16);          // CALL 16
      mem[1]   = enc(4'b0011, 6'd0, 6'd32);       // JZ R0 -> 32, taken
      mem[16]  = enc_t(4'b0100, 12'd24);          // CALL 24
      mem[17]  = enc(4'b1001, 6'd2, 6'd2);
      mem[18]  = enc(4'b0101, 6'd0, 6'd0);        // RET
      mem[24]  = enc(4'b0001, 6'd7, 6'd4);        // MOVE R7,R4
      mem[25]  = enc(4'b0101, 6'd0, 6'd0);        // RET
      mem[32]  = enc(4'b0011, 6'd3, 6'd5);        // JZ R3, not taken
      mem[33]  = enc(4'b0010, 6'd3, 6'd0);        // JMP {3,0} = 192
      mem[192] = enc(4'b0001, 6'd10, 6'd0);       // MOVE R10,R0
      mem[193] = enc(4'b0011, 6'd10, 6'd40);      // JZ R10 -> 40, taken
      mem[40]  = enc(4'b1111, 6'd0, 6'd0);        // HALT
      run_prog("R6");

      // ---- R8: eight-deep chain unwinds in LIFO order
      for (int ovf = 0; ovf < 2; ovf++) begin
         clear_mem();
         mem[0] = enc_t(4'b0100, 12'd16);
         mem[1] = enc(4'b1111, 6'd0, 6'd0);
         for (int j = 1; j < 8; j++) begin
            mem[16*j]   = enc_t(4'b0100, 12'(16*(j+1)));
            mem[16*j+1] = enc(4'b1001, 6'(j), 6'(j + 8));
            mem[16*j+2] = enc(4'b0101, 6'd0, 6'd0);
         end
         if (ovf == 0) begin
            mem[128] = enc(4'b1001, 6'd1, 6'd1);
            mem[129] = enc(4'b0101, 6'd0, 6'd0);
            run_prog("R8");
         end else begin
            // R9: ninth nested CALL finds the stack full
            mem[128] = enc_t(4'b0100, 12'd144);
            mem[144] = enc(4'b1001, 6'd1, 6'd1);
            run_prog("R9");
         end
      end

      // ---- R9: return with empty stack
      clear_mem();
      mem[0] = enc(4'b1001, 6'd1, 6'd2);
      mem[1] = enc(4'b0101, 6'd0, 6'd0);
      mem[2] = enc(4'b1001, 6'd3, 6'd3);
      run_prog("R9");

      // ---- R10: HALT at the first word
      clear_mem();
      mem[0] = enc(4'b1111, 6'd1, 6'd1);
      mem[1] = enc(4'b1001, 6'd4, 6'd4);
      run_prog("R10");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule